// File: doc/BRIEF.md
# Serial Register File Slave

This block is the device-side end of a four-wire serial link that a host drives by toggling general-purpose pins. The host supplies a serial clock, an active-low strobe and a data line into the block, and reads back a data line from it. All four signals are oversampled on a fast system clock. The block keeps a rolling history of the bits the host clocks in. It treats the one bit clocked while the strobe is low as a command that either stores a register or starts a read.

The register map holds three general control words, a reset word, a zero-extended DIP switch input and a constant version word. The control words appear as parallel outputs for the surrounding board logic. A write to the reset word with bit 0 set drives a fixed-length board reset pulse, after which the word clears itself. A read loads the addressed value into an output shifter, which the host clocks out over the 32 serial clocks that follow the command.

Top module: `sreg_slave`

## Requirements
- R1: While the strobe is high, each rising edge of the serial clock shifts the data-in level into a 40-bit history, MSB first. Only the last 40 bits count, so earlier stray bits have no effect.
- R2: A serial clock rising edge seen while the strobe is low is a command. Data-in 1 means write and data-in 0 means read. A read command changes no register.
- R3: On a write command, history bits [7:0] are the address and history bits [39:8] are the data. Addresses 0x00, 0x01 and 0x02 store into the words driven on mode_o, mux_o and video_o, and these words read back unchanged.
- R4: On a read command the addressed value is loaded, and its bit 31 is on ser_dout_o before the next serial clock rising edge. Each later bit appears after the falling edge that follows the rising edge that consumed the previous bit. After all 32 bits, ser_dout_o is 0.
- R5: Address 0x08 reads the DIP input zero-extended to 32 bits, and address 0xFF reads the VERSION parameter. Writes to either address change no readable value and no output.
- R6: Reads of any address outside 0x00, 0x01, 0x02, 0x08, 0x80 and 0xFF return 0, and writes to them change no output.
- R7: A write to 0x80 stores the data. If data bit 0 is 1, board_rst_o is high for exactly RST_LEN system clocks and then the word at 0x80 reads 0. If bit 0 is 0, there is no pulse and the word reads back as written.
- R8: While synchronous reset is high, all stored words are cleared, and ser_dout_o and board_rst_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock from the host |
| ser_stb_n_i | input | 1 | Active-low command strobe |
| ser_din_i | input | 1 | Serial data from the host |
| dip_i | input | DIP_W | DIP switch levels |
| ser_dout_o | output | 1 | Serial read data to the host |
| mode_o | output | 32 | Word at address 0x00 |
| mux_o | output | 32 | Word at address 0x01 |
| video_o | output | 32 | Word at address 0x02 |
| board_rst_o | output | 1 | Board reset pulse |

## Verification
On every cycle the assertions check that a decoded write lands in the control word it addresses and that each control word holds its value unless its own address is written. They also check that a reset write with bit 0 set starts the pulse and that the pulse never runs longer than RST_LEN cycles. The bench scenarios are needed for the parts that depend on whole frames: bit order and the 40-bit history window, the timing of the read shifter on the host's edges, the DIP and version readback, the zero returned for unmapped addresses, and the self-clearing of the reset word.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    localparam int DW     = 32;
    localparam int AW     = 8;
    localparam int HIST_W = DW + AW;

    localparam logic [AW-1:0] A_MODE  = 8'h00;
    localparam logic [AW-1:0] A_MUX   = 8'h01;
    localparam logic [AW-1:0] A_VIDEO = 8'h02;
    localparam logic [AW-1:0] A_DIP   = 8'h08;
    localparam logic [AW-1:0] A_RST   = 8'h80;
    localparam logic [AW-1:0] A_VER   = 8'hFF;

    typedef enum logic [2:0] {
        SEL_MODE, SEL_MUX, SEL_VIDEO, SEL_RST, SEL_DIP, SEL_VER, SEL_NONE
    } sel_e;

    typedef struct packed {
        logic          wr;
        logic          rd;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } cmd_t;

    function automatic sel_e decode(input logic [AW-1:0] a);
        case (a)
            A_MODE:  return SEL_MODE;
            A_MUX:   return SEL_MUX;
            A_VIDEO: return SEL_VIDEO;
            A_RST:   return SEL_RST;
            A_DIP:   return SEL_DIP;
            A_VER:   return SEL_VER;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) st[0] <= RST_VAL;
                else     st[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) st[i] <= RST_VAL;
                else     st[i] <= st[i-1];
            end
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/sreg_frame.sv
module sreg_frame
    import sreg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          sclk,
    input  logic          stb_n,
    input  logic          din,
    input  logic [DW-1:0] rd_data_i,
    output cmd_t          cmd_o,
    output logic          dout_o
);
    localparam int CW = $clog2(DW + 1);

    logic              sclk_q;
    logic              rise, fall;
    logic [HIST_W-1:0] hist;
    logic [DW-1:0]     tx_sr;
    logic [CW-1:0]     tx_left;
    logic              tx_pend;

    assign rise = sclk & ~sclk_q;
    assign fall = ~sclk & sclk_q;

    always_comb begin
        cmd_o.wr   = rise & ~stb_n & din;
        cmd_o.rd   = rise & ~stb_n & ~din;
        cmd_o.addr = hist[AW-1:0];
        cmd_o.data = hist[HIST_W-1:AW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            hist    <= '0;
            tx_sr   <= '0;
            tx_left <= '0;
            tx_pend <= 1'b0;
        end else begin
            sclk_q <= sclk;
            if (rise && stb_n)
                hist <= {hist[HIST_W-2:0], din};
            if (cmd_o.rd) begin
                tx_sr   <= rd_data_i;
                tx_left <= CW'(DW);
                tx_pend <= 1'b0;
            end else begin
                if (rise && stb_n && tx_left != '0) begin
                    tx_left <= tx_left - 1'b1;
                    tx_pend <= 1'b1;
                end
                if (fall && tx_pend) begin
                    tx_sr   <= {tx_sr[DW-2:0], 1'b0};
                    tx_pend <= 1'b0;
                end
            end
        end
    end

    assign dout_o = tx_sr[DW-1];
endmodule

// File: rtl/sreg_regs.sv
module sreg_regs
    import sreg_pkg::*;
#(
    parameter int          DIP_W   = 8,
    parameter logic [31:0] VERSION = 32'h0001_0203,
    parameter int          RST_LEN = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    data_i,
    input  logic [DIP_W-1:0] dip_i,
    output logic [DW-1:0]    rd_data_o,
    output logic [DW-1:0]    mode_o,
    output logic [DW-1:0]    mux_o,
    output logic [DW-1:0]    video_o,
    output logic             board_rst_o
);
    localparam int RCW = $clog2(RST_LEN + 1);

    logic [DW-1:0]  rstw_r;
    logic [RCW-1:0] rcnt;
    sel_e           sel;

    assign sel = decode(addr_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_o  <= '0;
            mux_o   <= '0;
            video_o <= '0;
            rstw_r  <= '0;
            rcnt    <= '0;
        end else begin
            if (rcnt != '0) begin
                rcnt <= rcnt - 1'b1;
                if (rcnt == RCW'(1)) rstw_r <= '0;
            end
            if (wr_i) begin
                case (sel)
                    SEL_MODE:  mode_o  <= data_i;
                    SEL_MUX:   mux_o   <= data_i;
                    SEL_VIDEO: video_o <= data_i;
                    SEL_RST: begin
                        rstw_r <= data_i;
                        if (data_i[0]) rcnt <= RCW'(RST_LEN);
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (sel)
            SEL_MODE:  rd_data_o = mode_o;
            SEL_MUX:   rd_data_o = mux_o;
            SEL_VIDEO: rd_data_o = video_o;
            SEL_RST:   rd_data_o = rstw_r;
            SEL_DIP:   rd_data_o = {{(DW-DIP_W){1'b0}}, dip_i};
            SEL_VER:   rd_data_o = VERSION;
            default:   rd_data_o = '0;
        endcase
    end

    assign board_rst_o = (rcnt != '0);
endmodule

// File: rtl/sreg_slave.sv
module sreg_slave
    import sreg_pkg::*;
#(
    parameter int          DIP_W       = 8,
    parameter logic [31:0] VERSION     = 32'h0001_0203,
    parameter int          RST_LEN     = 16,
    parameter int          SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_clk_i,
    input  logic             ser_stb_n_i,
    input  logic             ser_din_i,
    input  logic [DIP_W-1:0] dip_i,
    output logic             ser_dout_o,
    output logic [31:0]      mode_o,
    output logic [31:0]      mux_o,
    output logic [31:0]      video_o,
    output logic             board_rst_o
);
    logic [2:0]    pins_s;
    cmd_t          cmd;
    logic [DW-1:0] rd_data;

    sreg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ser_clk_i, ser_stb_n_i, ser_din_i}),
        .q   (pins_s)
    );

    sreg_frame u_frame (
        .clk       (clk),
        .rst       (rst),
        .sclk      (pins_s[2]),
        .stb_n     (pins_s[1]),
        .din       (pins_s[0]),
        .rd_data_i (rd_data),
        .cmd_o     (cmd),
        .dout_o    (ser_dout_o)
    );

    sreg_regs #(.DIP_W(DIP_W), .VERSION(VERSION), .RST_LEN(RST_LEN)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_i        (cmd.wr),
        .addr_i      (cmd.addr),
        .data_i      (cmd.data),
        .dip_i       (dip_i),
        .rd_data_o   (rd_data),
        .mode_o      (mode_o),
        .mux_o       (mux_o),
        .video_o     (video_o),
        .board_rst_o (board_rst_o)
    );
endmodule

// File: rtl/sreg_slave_chk.sv
module sreg_slave_chk
    import sreg_pkg::*;
#(
    parameter int RST_LEN = 16
) (
    input logic        clk,
    input logic        rst,
    input cmd_t        cmd,
    input logic [31:0] mode,
    input logic [31:0] mux,
    input logic [31:0] video,
    input logic        board_rst
);
    int unsigned hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)            hi_cnt <= 0;
        else if (board_rst) hi_cnt <= hi_cnt + 1;
        else                hi_cnt <= 0;
    end

    a_r3_mode_write: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr && cmd.addr == A_MODE) |=> (mode == $past(cmd.data)));

    a_r3_mux_write: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr && cmd.addr == A_MUX) |=> (mux == $past(cmd.data)));

    // R5 and R6: control words move only on a write to their own address
    a_r6_mode_hold: assert property (@(posedge clk) disable iff (rst)
        !(cmd.wr && cmd.addr == A_MODE) |=> $stable(mode));

    a_r6_video_hold: assert property (@(posedge clk) disable iff (rst)
        !(cmd.wr && cmd.addr == A_VIDEO) |=> $stable(video));

    a_r7_pulse_start: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr && cmd.addr == A_RST && cmd.data[0]) |=> board_rst);

    a_r7_pulse_len: assert property (@(posedge clk) disable iff (rst)
        board_rst |-> (hi_cnt < RST_LEN));
endmodule

bind sreg_slave sreg_slave_chk #(.RST_LEN(RST_LEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .mode      (mode_o),
    .mux       (mux_o),
    .video     (video_o),
    .board_rst (board_rst_o)
);

// File: tb/sim_sreg_slave.sv
module sim_sreg_slave;
    localparam int          CLK_PERIOD = 10;
    localparam int          H          = 8;
    localparam int          RST_LEN    = 16;
    localparam logic [31:0] VER        = 32'h0001_0203;
    localparam logic [7:0]  DIP        = 8'hA5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0, stb_n = 1'b1, din = 1'b0;
    logic [7:0]  dip = DIP;
    logic        dout, brst;
    logic [31:0] mode, mux, video;

    int n_chk = 0, n_fail = 0, rst_hi = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (brst) rst_hi++;

    sreg_slave #(.DIP_W(8), .VERSION(VER), .RST_LEN(RST_LEN), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_stb_n_i(stb_n), .ser_din_i(din),
        .dip_i(dip), .ser_dout_o(dout), .mode_o(mode), .mux_o(mux), .video_o(video),
        .board_rst_o(brst)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        din = b;
        wait_n(H);
        sclk = 1'b1;
        wait_n(H);
        sclk = 1'b0;
    endtask

    task automatic send_cmd(input logic is_wr);
        din   = is_wr;
        stb_n = 1'b0;
        wait_n(H);
        sclk = 1'b1;
        wait_n(H);
        sclk = 1'b0;
        wait_n(H);
        stb_n = 1'b1;
        din   = 1'b0;
    endtask

    task automatic wr_frame(input logic [7:0] a, input logic [31:0] d);
        for (int i = 31; i >= 0; i--) send_bit(d[i]);
        for (int i = 7; i >= 0; i--)  send_bit(a[i]);
        send_cmd(1'b1);
        wait_n(H);
    endtask

    task automatic rd_frame(input logic [7:0] a, output logic [31:0] d);
        for (int i = 7; i >= 0; i--) send_bit(a[i]);
        send_cmd(1'b0);
        for (int i = 31; i >= 0; i--) begin
            wait_n(H);
            d[i] = dout;
            sclk = 1'b1;
            wait_n(H);
            sclk = 1'b0;
        end
        wait_n(H);
    endtask

    task automatic t_reset_state;
        check("R8 mode", mode, 0);
        check("R8 mux", mux, 0);
        check("R8 video", video, 0);
        check("R8 dout", {31'd0, dout}, 0);
        check("R8 board_rst", {31'd0, brst}, 0);
    endtask

    task automatic t_rw_words;
        logic [31:0] r;
        wr_frame(8'h00, 32'hDEAD_BEEF);
        check("R3 mode_o", mode, 32'hDEAD_BEEF);
        wr_frame(8'h01, 32'h8000_0001);
        check("R3 mux_o", mux, 32'h8000_0001);
        check("R3 mode kept", mode, 32'hDEAD_BEEF);
        rd_frame(8'h00, r);
        check("R4 read mode MSB first", r, 32'hDEAD_BEEF);
        check("R4 dout zero after read", {31'd0, dout}, 0);
        check("R2 read leaves mode", mode, 32'hDEAD_BEEF);
        rd_frame(8'h01, r);
        check("R4 read mux", r, 32'h8000_0001);
    endtask

    task automatic t_history;
        logic [31:0] r;
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        send_bit(1'b1); send_bit(1'b1);
        wr_frame(8'h02, 32'h1234_5678);
        check("R1 video with leading junk", video, 32'h1234_5678);
        rd_frame(8'h02, r);
        check("R3 read video", r, 32'h1234_5678);
    endtask

    task automatic t_readonly;
        logic [31:0] r;
        rd_frame(8'h08, r);
        check("R5 dip read", r, {24'd0, DIP});
        rd_frame(8'hFF, r);
        check("R5 version read", r, VER);
        wr_frame(8'hFF, 32'hFFFF_FFFF);
        wr_frame(8'h08, 32'h0000_0F0F);
        rd_frame(8'hFF, r);
        check("R5 version after write", r, VER);
        rd_frame(8'h08, r);
        check("R5 dip after write", r, {24'd0, DIP});
        check("R5 mode unchanged", mode, 32'hDEAD_BEEF);
    endtask

    task automatic t_unmapped;
        logic [31:0] r;
        wr_frame(8'h03, 32'h5555_AAAA);
        check("R6 mode unchanged", mode, 32'hDEAD_BEEF);
        check("R6 mux unchanged", mux, 32'h8000_0001);
        check("R6 video unchanged", video, 32'h1234_5678);
        rd_frame(8'h03, r);
        check("R6 read 0x03", r, 0);
        rd_frame(8'h40, r);
        check("R6 read 0x40", r, 0);
    endtask

    task automatic t_reset_pulse;
        logic [31:0] r;
        rst_hi = 0;
        wr_frame(8'h80, 32'h0000_0002);
        wait_n(RST_LEN + 4);
        check("R7 no pulse on bit0=0", rst_hi, 0);
        rd_frame(8'h80, r);
        check("R7 reset word kept", r, 32'h2);
        rst_hi = 0;
        wr_frame(8'h80, 32'h0000_0001);
        wait_n(RST_LEN + 4);
        check("R7 pulse length", rst_hi, RST_LEN);
        check("R7 pulse ended", {31'd0, brst}, 0);
        rd_frame(8'h80, r);
        check("R7 self clear", r, 0);
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        wait_n(5);
        t_reset_state();
        rst = 1'b0;
        wait_n(5);
        t_rw_words();
        t_history();
        t_readonly();
        t_unmapped();
        t_reset_pulse();
        report();
    end
endmodule